// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device side of a simplified ATA disk controller. A host reaches it through a small register window: eight offsets, selected by a 3-bit address, with 8-bit writes and 16-bit reads. The block holds the sector count, the three LBA bytes and the device/head byte. It also keeps the status byte, which it advances through the phases of each command.

Three command groups are understood. IDENTIFY streams 256 generated 16-bit words out of the data register as a PIO data-in transfer. The words carry a space-padded ASCII serial number and firmware string, the write-cache flag and the capacity. FLUSH CACHE holds the device busy for a parameterised number of cycles, or until an external completion strobe arrives. READ DMA and WRITE DMA hand the latched 24-bit LBA and the sector count to an external DMA engine with a one-cycle start pulse, and stay busy until that engine reports completion. Any other command code is rejected with an error.

A level interrupt is raised on every completion or data-ready event. The host acknowledges it by reading the status register.

Top module: `ata_tf_ctrl`

## Requirements
- R1: After reset the status byte reads 0x40 (only DRDY), the interrupt is low and the DMA start pulse is low.
- R2: Bytes written at offset 2 (sector count), 3 (LBA bits 7:0), 4 (LBA bits 15:8), 5 (LBA bits 23:16) and 6 (device) read back unchanged at the same offset. Writing 0x40 to the device register reads back with bit 4 (device-1 select) clear.
- R3: Writing 0xEC to offset 7 starts a 256-word PIO transfer. While words remain, status reads 0x48 (DRDY and DRQ, with BSY=0x80, DF=0x20 and ERR=0x01 clear). Each data read at offset 0 returns the next word. After the 256th read, status reads 0x40.
- R4: IDENTIFY word 0 is 0x0040 and word 49 is 0x0200. Words 10 to 19 hold the 20-character serial string and words 23 to 26 the 8-character firmware string, with character 2k in the high byte and character 2k+1 in the low byte. Words 60 and 61 hold capacity bits 15:0 and 31:16. Word 85 is 0x0020 (bit 5: write cache on). Every other word is zero.
- R5: A data read while DRQ is clear returns 0 and does not advance the word pointer.
- R6: Writing 0xE7 makes status read 0xC0 (BSY and DRDY) for FLUSH_CYCLES cycles after the write edge. Status then reads 0x40 and the interrupt is raised.
- R7: A pulse on flush_done during a flush ends the busy phase at that clock edge, with status 0x40 and the interrupt raised.
- R8: Writing 0xC8 or 0xCA pulses dma_start for exactly the one cycle after the write edge. dma_write is 0 for 0xC8 and 1 for 0xCA. dma_lba is {offset 5, offset 4, offset 3} and dma_count is offset 2. Status reads 0xC0 until a dma_done pulse, after which it reads 0x40 with the interrupt raised.
- R9: Any other command code sets status to 0x41 (DRDY and ERR) and raises the interrupt. The next accepted command clears ERR.
- R10: Entering the IDENTIFY data phase raises the interrupt. A read at offset 7 clears it at that clock edge, and reads at other offsets leave it set.
- R11: While BSY or DRQ is set, writes to offset 7 and to offsets 2 to 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one per cycle |
| reg_rd | input | 1 | Read strobe; its side effects occur at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| flush_done | input | 1 | Early completion strobe for a flush |
| dma_done | input | 1 | Completion strobe from the DMA engine |
| irq | output | 1 | Interrupt request, level |
| dma_start | output | 1 | One-cycle pulse that starts a DMA transfer |
| dma_write | output | 1 | DMA direction, 1 = host to media |
| dma_lba | output | 24 | Logical block address handed to the DMA engine |
| dma_count | output | 8 | Sector count handed to the DMA engine |

## Verification
Read data is combinational on the offset and the current state. The bench samples it one time step after it drives the address, and the side effects of the read (pointer advance, interrupt acknowledge) show up only after the next clock edge. Command effects on status, interrupt and dma_start are due in the cycle that follows the write edge, so they are checked right after the falling edge that ends the write. A flush is checked at FLUSH_CYCLES-1 and at FLUSH_CYCLES falling edges after the command: busy at the first point, idle at the second. Strobe-driven completions are checked in the cycle just after the strobe edge.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_DRDY = 8'h40;
  localparam logic [7:0] ST_DF   = 8'h20;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_ERR  = 8'h01;

  localparam logic [7:0] OP_IDENT  = 8'hEC;
  localparam logic [7:0] OP_FLUSH  = 8'hE7;
  localparam logic [7:0] OP_DMA_RD = 8'hC8;
  localparam logic [7:0] OP_DMA_WR = 8'hCA;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_COUNT = 3'd2;
  localparam logic [2:0] OFS_LBA0  = 3'd3;
  localparam logic [2:0] OFS_DEV   = 3'd6;
  localparam logic [2:0] OFS_CMDST = 3'd7;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PIO_IN = 2'd1,
    PH_FLUSH  = 2'd2,
    PH_DMA    = 2'd3
  } phase_e;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int LBA_BYTES = 3,
  localparam int LBA_W = 8 * LBA_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       count,
  output logic [LBA_W-1:0] lba,
  output logic [7:0]       dev
);
  logic [7:0] count_q, count_d;
  logic [7:0] dev_q, dev_d;

  always_comb begin
    count_d = count_q;
    dev_d   = dev_q;
    if (wr_en && addr == OFS_COUNT) count_d = wdata;
    if (wr_en && addr == OFS_DEV)   dev_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= 8'h00;
      dev_q   <= 8'h00;
    end else begin
      count_q <= count_d;
      dev_q   <= dev_d;
    end
  end

  for (genvar g = 0; g < LBA_BYTES; g++) begin : g_lba
    logic [7:0] byte_q, byte_d;
    logic       hit;
    assign hit = wr_en && (addr == OFS_LBA0 + 3'(g));
    always_comb begin
      byte_d = hit ? wdata : byte_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= 8'h00;
      else        byte_q <= byte_d;
    end
    assign lba[8*g +: 8] = byte_q;
  end

  assign count = count_q;
  assign dev   = dev_q;
endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
  parameter int WORDS = 256,
  parameter int SER_CHARS = 20,
  parameter int VER_CHARS = 8,
  parameter logic [8*SER_CHARS-1:0] SERIAL = "UNIT0001            ",
  parameter logic [8*VER_CHARS-1:0] VERSION = "FW 1.00 ",
  parameter logic [31:0] CAPACITY = 32'h0002_0000,
  localparam int IDX_W = $clog2(WORDS),
  localparam int SER_W0 = 10,
  localparam int SER_W1 = SER_W0 + SER_CHARS / 2,
  localparam int VER_W0 = 23,
  localparam int VER_W1 = VER_W0 + VER_CHARS / 2
) (
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      word
);
  function automatic logic [7:0] ser_ch(input int p);
    return SERIAL[8*(SER_CHARS-1-p) +: 8];
  endfunction

  function automatic logic [7:0] ver_ch(input int p);
    return VERSION[8*(VER_CHARS-1-p) +: 8];
  endfunction

  always_comb begin
    int ix;
    int k;
    ix   = int'(idx);
    k    = 0;
    word = 16'h0000;
    if (ix >= SER_W0 && ix < SER_W1) begin
      k    = ix - SER_W0;
      word = {ser_ch(2*k), ser_ch(2*k+1)};
    end else if (ix >= VER_W0 && ix < VER_W1) begin
      k    = ix - VER_W0;
      word = {ver_ch(2*k), ver_ch(2*k+1)};
    end else begin
      case (ix)
        0:       word = 16'h0040;
        49:      word = 16'h0200;
        60:      word = CAPACITY[15:0];
        61:      word = CAPACITY[31:16];
        85:      word = 16'h0020;
        default: word = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
#(
  parameter int FLUSH_CYCLES = 16,
  parameter int WORDS = 256,
  localparam int IDX_W = $clog2(WORDS),
  localparam int CNT_W = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             data_rd,
  input  logic             status_rd,
  input  logic             flush_done,
  input  logic             dma_done,
  output logic [7:0]       status,
  output logic             irq,
  output logic [IDX_W-1:0] word_idx,
  output phase_e           phase,
  output logic             dma_start,
  output logic             dma_write
);
  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             irq_q, irq_d;
  logic             start_q, start_d;
  logic             dir_q, dir_d;
  logic             raise;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    dir_d   = dir_q;
    start_d = 1'b0;
    raise   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (cmd_wr) begin
          err_d = 1'b0;
          case (cmd_code)
            OP_IDENT: begin
              phase_d = PH_PIO_IN;
              idx_d   = '0;
              raise   = 1'b1;
            end
            OP_FLUSH: begin
              phase_d = PH_FLUSH;
              cnt_d   = CNT_W'(FLUSH_CYCLES - 1);
            end
            OP_DMA_RD, OP_DMA_WR: begin
              phase_d = PH_DMA;
              start_d = 1'b1;
              dir_d   = (cmd_code == OP_DMA_WR);
            end
            default: begin
              err_d = 1'b1;
              raise = 1'b1;
            end
          endcase
        end
      end
      PH_PIO_IN: begin
        if (data_rd) begin
          if (idx_q == IDX_W'(WORDS - 1)) phase_d = PH_IDLE;
          else                            idx_d   = idx_q + 1'b1;
        end
      end
      PH_FLUSH: begin
        if (flush_done || cnt_q == '0) begin
          phase_d = PH_IDLE;
          raise   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_DMA: begin
        if (dma_done) begin
          phase_d = PH_IDLE;
          raise   = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase

    if (raise)          irq_d = 1'b1;
    else if (status_rd) irq_d = 1'b0;
    else                irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
      start_q <= start_d;
      dir_q   <= dir_d;
    end
  end

  always_comb begin
    case (phase_q)
      PH_PIO_IN:        status = ST_DRDY | ST_DRQ;
      PH_FLUSH, PH_DMA: status = ST_BSY | ST_DRDY;
      default:          status = ST_DRDY | (err_q ? ST_ERR : 8'h00);
    endcase
  end

  assign irq       = irq_q;
  assign word_idx  = idx_q;
  assign phase     = phase_q;
  assign dma_start = start_q;
  assign dma_write = dir_q;
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
#(
  parameter int FLUSH_CYCLES = 16,
  parameter int WORDS = 256,
  parameter int SER_CHARS = 20,
  parameter int VER_CHARS = 8,
  parameter logic [8*SER_CHARS-1:0] SERIAL = "UNIT0001            ",
  parameter logic [8*VER_CHARS-1:0] VERSION = "FW 1.00 ",
  parameter logic [31:0] CAPACITY = 32'h0002_0000,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        flush_done,
  input  logic        dma_done,
  output logic        irq,
  output logic        dma_start,
  output logic        dma_write,
  output logic [23:0] dma_lba,
  output logic [7:0]  dma_count
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [7:0]       st_byte;
  logic [7:0]       dev_byte;
  logic [IDX_W-1:0] word_idx;
  logic [15:0]      id_word;
  phase_e           phase;
  logic             busy;
  logic             tf_wr;
  logic             cmd_wr;
  logic             data_rd;
  logic             status_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign busy      = st_byte[7] | st_byte[3];
  assign tf_wr     = reg_wr && !busy && (reg_addr != OFS_CMDST);
  assign cmd_wr    = reg_wr && (reg_addr == OFS_CMDST);
  assign data_rd   = reg_rd && (reg_addr == OFS_DATA);
  assign status_rd = reg_rd && (reg_addr == OFS_CMDST);

  ata_tf_regs #(.LBA_BYTES(3)) u_regs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_en (tf_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .count (dma_count),
    .lba   (dma_lba),
    .dev   (dev_byte)
  );

  ata_tf_seq #(.FLUSH_CYCLES(FLUSH_CYCLES), .WORDS(WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cmd_wr     (cmd_wr),
    .cmd_code   (reg_wdata),
    .data_rd    (data_rd),
    .status_rd  (status_rd),
    .flush_done (flush_done),
    .dma_done   (dma_done),
    .status     (st_byte),
    .irq        (irq),
    .word_idx   (word_idx),
    .phase      (phase),
    .dma_start  (dma_start),
    .dma_write  (dma_write)
  );

  ata_tf_ident #(
    .WORDS     (WORDS),
    .SER_CHARS (SER_CHARS),
    .VER_CHARS (VER_CHARS),
    .SERIAL    (SERIAL),
    .VERSION   (VERSION),
    .CAPACITY  (CAPACITY)
  ) u_ident (
    .idx  (word_idx),
    .word (id_word)
  );

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = (phase == PH_PIO_IN) ? id_word : 16'h0000;
      3'd2:    reg_rdata = {8'h00, dma_count};
      3'd3:    reg_rdata = {8'h00, dma_lba[7:0]};
      3'd4:    reg_rdata = {8'h00, dma_lba[15:8]};
      3'd5:    reg_rdata = {8'h00, dma_lba[23:16]};
      3'd6:    reg_rdata = {8'h00, dev_byte};
      3'd7:    reg_rdata = {8'h00, st_byte};
      default: reg_rdata = 16'h0000;
    endcase
  end
endmodule

module ata_tf_chk
  import ata_tf_pkg::*;
#(
  parameter int FLUSH_CYCLES = 16,
  parameter int IDX_W = 8,
  localparam int RUN_W = $clog2(FLUSH_CYCLES + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             irq,
  input logic             dma_start,
  input logic [7:0]       status,
  input phase_e           phase,
  input logic [IDX_W-1:0] word_idx
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (phase == PH_FLUSH) run_q <= run_q + 1'b1;
    else                        run_q <= '0;
  end

  assert_bsy_drq_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3]));

  assert_pio_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PIO_IN) |-> (status == 8'h48));

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd0 && !reg_wr && phase != PH_PIO_IN) |=> $stable(word_idx));

  assert_irq_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd7 && !reg_wr && phase == PH_IDLE) |=> !irq);

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  assert_flush_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FLUSH) |-> (run_q < RUN_W'(FLUSH_CYCLES)));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd7 && phase == PH_FLUSH) |=> (phase != PH_PIO_IN));
endmodule

bind ata_tf_ctrl ata_tf_chk #(.FLUSH_CYCLES(FLUSH_CYCLES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .irq       (irq),
  .dma_start (dma_start),
  .status    (st_byte),
  .phase     (phase),
  .word_idx  (word_idx)
);

// File: tb/test_ata_tf_ctrl.sv
`timescale 1ns/1ps
module test_ata_tf_ctrl;
  localparam int FLUSH_N = 16;
  localparam logic [31:0] CAP = 32'h0002_0000;
  localparam logic [159:0] SER_P = "UNIT0001            ";
  localparam logic [63:0] VER_P = "FW 1.00 ";
  localparam string SER_S = "UNIT0001            ";
  localparam string VER_S = "FW 1.00 ";

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [15:0] reg_rdata;
  logic        flush_done = 1'b0;
  logic        dma_done = 1'b0;
  logic        irq;
  logic        dma_start;
  logic        dma_write;
  logic [23:0] dma_lba;
  logic [7:0]  dma_count;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ata_tf_ctrl #(
    .FLUSH_CYCLES(FLUSH_N), .SERIAL(SER_P), .VERSION(VER_P), .CAPACITY(CAP)
  ) i_ata_tf_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flush_done(flush_done), .dma_done(dma_done), .irq(irq),
    .dma_start(dma_start), .dma_write(dma_write), .dma_lba(dma_lba),
    .dma_count(dma_count)
  );

  // {offset, write value, expected read-back}, register decode (R2)
  localparam int NVEC = 7;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd2, 8'h05, 8'h05},
    {8'd3, 8'h34, 8'h34},
    {8'd4, 8'h12, 8'h12},
    {8'd5, 8'hAB, 8'hAB},
    {8'd6, 8'h50, 8'h50},
    {8'd6, 8'hE0, 8'hE0},
    {8'd6, 8'h40, 8'h40}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek_status(output logic [7:0] v);
    reg_addr = 3'd7;
    #1 v = reg_rdata[7:0];
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_done = 1'b1;
    @(negedge clk); flush_done = 1'b0;
  endtask

  task automatic pulse_dma();
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(input int i);
    if (i >= 10 && i < 20) return {SER_S[2*(i-10)], SER_S[2*(i-10)+1]};
    if (i >= 23 && i < 27) return {VER_S[2*(i-23)], VER_S[2*(i-23)+1]};
    case (i)
      0:  return 16'h0040;
      49: return 16'h0200;
      60: return CAP[15:0];
      61: return CAP[31:16];
      85: return 16'h0020;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek_status(st);
    check(st, 8'h40, "R1 status");
    check(irq, 0, "R1 irq");
    check(dma_start, 0, "R1 dma_start");

    // R2 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      check(v, {8'h00, VEC[i][7:0]}, "R2 readback");
    end
    rd(3'd6, v);
    check(v[4], 0, "R2 device bit4 clear");

    // R5 data read idle
    for (int i = 0; i < 3; i++) begin
      rd(3'd0, v);
      check(v, 0, "R5 idle data read");
    end

    // R3/R4/R10 identify
    wr(3'd7, 8'hEC);
    check(irq, 1, "R10 irq on data ready");
    peek_status(st);
    check(st, 8'h48, "R3 drq status");
    rd(3'd3, v);
    check(irq, 1, "R10 non-status read keeps irq");
    rd(3'd7, v);
    check(irq, 0, "R10 status read clears irq");
    for (int i = 0; i < 256; i++) begin
      peek_status(st);
      if (st !== 8'h48) check(st, 8'h48, "R3 status during transfer");
      rd(3'd0, v);
      check(v, exp_word(i), "R4 identify word");
    end
    peek_status(st);
    check(st, 8'h40, "R3 status after last word");
    rd(3'd0, v);
    check(v, 0, "R5 data read after transfer");

    // R11 writes ignored while DRQ
    wr(3'd7, 8'hEC);
    wr(3'd2, 8'h77);
    wr(3'd7, 8'hE7);
    peek_status(st);
    check(st, 8'h48, "R11 command ignored during DRQ");
    for (int i = 0; i < 256; i++) rd(3'd0, v);
    rd(3'd2, v);
    check(v, 16'h0005, "R11 count write ignored");
    rd(3'd7, v);

    // R6 flush timed
    wr(3'd7, 8'hE7);
    peek_status(st);
    check(st, 8'hC0, "R6 busy at start");
    repeat (FLUSH_N - 1) @(negedge clk);
    peek_status(st);
    check(st, 8'hC0, "R6 busy at last cycle");
    @(negedge clk);
    peek_status(st);
    check(st, 8'h40, "R6 done");
    check(irq, 1, "R6 irq");
    rd(3'd7, v);

    // R7 early flush completion, with ignored command (R11)
    wr(3'd7, 8'hE7);
    wr(3'd7, 8'hEC);
    peek_status(st);
    check(st, 8'hC0, "R11 command ignored during BSY");
    check(irq, 0, "R7 no irq while busy");
    pulse_flush();
    peek_status(st);
    check(st, 8'h40, "R7 early done");
    check(irq, 1, "R7 irq");
    rd(3'd7, v);

    // R8 DMA read
    wr(3'd7, 8'hC8);
    check(dma_start, 1, "R8 start pulse");
    check(dma_write, 0, "R8 read direction");
    check(dma_lba, 24'hAB1234, "R8 lba");
    check(dma_count, 8'h05, "R8 count");
    peek_status(st);
    check(st, 8'hC0, "R8 busy");
    @(negedge clk);
    check(dma_start, 0, "R8 pulse width");
    pulse_dma();
    peek_status(st);
    check(st, 8'h40, "R8 done");
    check(irq, 1, "R8 irq");
    rd(3'd7, v);
    wr(3'd7, 8'hCA);
    check(dma_start, 1, "R8 start write");
    check(dma_write, 1, "R8 write direction");
    pulse_dma();
    rd(3'd7, v);

    // R9 unknown command
    wr(3'd7, 8'h20);
    peek_status(st);
    check(st, 8'h41, "R9 error status");
    check(irq, 1, "R9 irq");
    rd(3'd7, v);
    check(irq, 0, "R9 irq ack");
    wr(3'd7, 8'hE7);
    peek_status(st);
    check(st, 8'hC0, "R9 err cleared");
    pulse_flush();

    finished = 1;
    summary();
    $finish;
  end
endmodule